// File: doc/BRIEF.md
# Four-Window Bus Address Translator

This block turns a local-bus address into a PCI-side address. A 64 MB memory aperture on the local bus is cut into four consecutive 16 MB windows. Each window has its own upper address byte, and all four bytes are packed into one 32-bit memory base register. Address bits [25:24] of the request choose the window. The low 24 bits of the request pass through unchanged below the chosen byte.

A second register holds a 24-bit base for I/O requests. The translated I/O address is that base with the low 8 request bits below it, so an I/O region always starts on a 256-byte boundary.

Software loads the two registers through a small write port. Each request arrives with a valid strobe and a memory/I-O selector. One clock later the block presents the translated address and a flag that says whether the request fell inside the aperture the block serves.

Top module: `bwx_translator`

## Requirements
- R1: While reset is asserted, and right after it, both base registers read as zero and `xl_valid`, `xl_hit` and `xl_addr` are 0. A request made after reset therefore translates with all-zero bases.
- R2: For a memory request, window k (k = `req_addr[25:24]`) takes its upper byte from bits [31-8k : 24-8k] of the memory base register. Window 0 uses bits [31:24] and window 3 uses bits [7:0].
- R3: For an in-range memory request, `xl_addr` equals {selected window byte, `req_addr[23:0]`}.
- R4: A write to the I/O base keeps only `cfg_wdata[23:0]`, and bits [31:24] of that write are discarded. For an in-range I/O request (`req_io`=1), `xl_addr` equals {I/O base[23:0], `req_addr[7:0]`}.
- R5: A memory request is in range when `req_addr[31:26]` equals `MEM_TAG` (default 6'h12). An I/O request is in range when `req_addr[31:8]` equals `IO_PAGE` (default 24'hFFFFFC). An out-of-range request gives `xl_hit`=0 and `xl_addr`=0.
- R6: `xl_valid` follows `req_valid` one clock later. `xl_addr` and `xl_hit` change only one clock after a valid request, and otherwise they hold their value.
- R7: With `cfg_we`=1, offset 8'h34 writes the memory base and offset 8'h30 writes the I/O base. Writes to any other offset change neither register.
- R8: A register write and a request in the same clock give the request the old register value. The new value applies from the next clock on.
- R9: Memory base bytes loaded as {b, b+1, b+2, b+3} map the 64 MB aperture linearly: `xl_addr` = (b << 24) + `req_addr[25:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_off | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Local-bus address |
| xl_valid | output | 1 | Translated result valid |
| xl_addr | output | 32 | Translated bus address |
| xl_hit | output | 1 | Request was inside the served aperture |

## Verification
A translated address, its hit flag and its valid strobe are all due exactly one rising edge after the edge that captures the request. The bench drives each request on a falling edge and compares at the next falling edge, which is after that single register stage. A register write takes effect on the edge that captures it, so the bench steps its shadow copy of the registers at that same point. For a write and a request in the same cycle, it computes the expected value from the shadow as it was before the write. To check the hold behaviour, the bench changes the request address during an idle cycle and confirms that the outputs did not move.

// File: rtl/bwx_pkg.sv
package bwx_pkg;
  localparam int unsigned BWX_ADDR_W = 32;
  localparam int unsigned BWX_OFF_W  = 8;
  localparam logic [BWX_OFF_W-1:0] OFF_IO_BASE  = 8'h30;
  localparam logic [BWX_OFF_W-1:0] OFF_MEM_BASE = 8'h34;

  typedef struct packed {
    logic                  hit;
    logic [BWX_ADDR_W-1:0] addr;
  } xlat_res_t;
endpackage

// File: rtl/bwx_rst_sync.sv
module bwx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bwx_cfg_regs.sv
module bwx_cfg_regs #(
  parameter int unsigned ADDR_W    = bwx_pkg::BWX_ADDR_W,
  parameter int unsigned OFF_W     = bwx_pkg::BWX_OFF_W,
  parameter int unsigned IO_KEEP_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [OFF_W-1:0]     off,
  input  logic [ADDR_W-1:0]    wdata,
  output logic [ADDR_W-1:0]    mem_base,
  output logic [IO_KEEP_W-1:0] io_base
);
  logic [ADDR_W-1:0]    mem_q, mem_d;
  logic [IO_KEEP_W-1:0] io_q, io_d;
  logic                 mem_en, io_en;

  always_comb begin
    mem_en = we && (off == bwx_pkg::OFF_MEM_BASE);
    io_en  = we && (off == bwx_pkg::OFF_IO_BASE);
    mem_d  = wdata;
    io_d   = wdata[IO_KEEP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      io_q  <= '0;
    end else begin
      if (mem_en) mem_q <= mem_d;
      if (io_en)  io_q  <= io_d;
    end
  end

  assign mem_base = mem_q;
  assign io_base  = io_q;

  // R7: other offsets leave both registers untouched
  assert_other_off_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off != bwx_pkg::OFF_MEM_BASE && off != bwx_pkg::OFF_IO_BASE)
      |=> ($stable(mem_base) && $stable(io_base)));

  // R4: I/O base keeps the low bits of the written word
  assert_io_low_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == bwx_pkg::OFF_IO_BASE) |=> io_base == $past(wdata[IO_KEEP_W-1:0]));
endmodule

// File: rtl/bwx_xlat_core.sv
module bwx_xlat_core #(
  parameter int unsigned ADDR_W     = bwx_pkg::BWX_ADDR_W,
  parameter int unsigned WIN_SEL_W  = 2,
  parameter int unsigned WIN_SPAN_W = 24,
  parameter int unsigned IO_KEEP_W  = 24,
  parameter logic [ADDR_W-WIN_SPAN_W-WIN_SEL_W-1:0] MEM_TAG = 6'h12,
  parameter logic [IO_KEEP_W-1:0] IO_PAGE = 24'hFFFFFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    mem_base,
  input  logic [IO_KEEP_W-1:0] io_base,
  input  logic                 req_valid,
  input  logic                 req_io,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_hit
);
  localparam int unsigned NUM_WIN  = 1 << WIN_SEL_W;
  localparam int unsigned BYTE_W   = ADDR_W - WIN_SPAN_W;
  localparam int unsigned TAG_W    = ADDR_W - WIN_SPAN_W - WIN_SEL_W;
  localparam int unsigned IO_OFF_W = ADDR_W - IO_KEEP_W;

  logic [BYTE_W-1:0]    win_hi [NUM_WIN];
  logic [WIN_SEL_W-1:0] win_sel;
  bwx_pkg::xlat_res_t   res_d, res_q;
  logic                 valid_q;

  // Window 0 owns the top byte; higher windows walk down the register.
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hi[g] = mem_base[(NUM_WIN-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    win_sel = req_addr[WIN_SPAN_W +: WIN_SEL_W];
    if (req_io) begin
      res_d.hit  = (req_addr[ADDR_W-1 -: IO_KEEP_W] == IO_PAGE);
      res_d.addr = {io_base, req_addr[IO_OFF_W-1:0]};
    end else begin
      res_d.hit  = (req_addr[ADDR_W-1 -: TAG_W] == MEM_TAG);
      res_d.addr = {win_hi[win_sel], req_addr[WIN_SPAN_W-1:0]};
    end
    if (!res_d.hit) res_d.addr = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) res_q <= res_d;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = res_q.addr;
  assign out_hit   = res_q.hit;

  // R6: one-cycle valid latency
  assert_valid_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R6: result held without a request
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_addr) && $stable(out_hit)));
  // R5: a miss reports a zero address
  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> out_addr == '0);
  // R3: low span passes straight through for a memory hit
  assert_mem_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && req_addr[ADDR_W-1 -: TAG_W] == MEM_TAG)
      |=> (out_hit && out_addr[WIN_SPAN_W-1:0] == $past(req_addr[WIN_SPAN_W-1:0])));
endmodule

// File: rtl/bwx_translator.sv
module bwx_translator #(
  parameter int unsigned ADDR_W     = bwx_pkg::BWX_ADDR_W,
  parameter int unsigned WIN_SEL_W  = 2,
  parameter int unsigned WIN_SPAN_W = 24,
  parameter int unsigned IO_KEEP_W  = 24,
  parameter logic [ADDR_W-WIN_SPAN_W-WIN_SEL_W-1:0] MEM_TAG = 6'h12,
  parameter logic [IO_KEEP_W-1:0] IO_PAGE = 24'hFFFFFC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [bwx_pkg::BWX_OFF_W-1:0] cfg_off,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  input  logic                          req_valid,
  input  logic                          req_io,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          xl_valid,
  output logic [ADDR_W-1:0]             xl_addr,
  output logic                          xl_hit
);
  logic                 rst_n_int;
  logic [ADDR_W-1:0]    mem_base;
  logic [IO_KEEP_W-1:0] io_base;

  bwx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bwx_cfg_regs #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (bwx_pkg::BWX_OFF_W),
    .IO_KEEP_W (IO_KEEP_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .we       (cfg_we),
    .off      (cfg_off),
    .wdata    (cfg_wdata),
    .mem_base (mem_base),
    .io_base  (io_base)
  );

  bwx_xlat_core #(
    .ADDR_W     (ADDR_W),
    .WIN_SEL_W  (WIN_SEL_W),
    .WIN_SPAN_W (WIN_SPAN_W),
    .IO_KEEP_W  (IO_KEEP_W),
    .MEM_TAG    (MEM_TAG),
    .IO_PAGE    (IO_PAGE)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mem_base  (mem_base),
    .io_base   (io_base),
    .req_valid (req_valid),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .out_valid (xl_valid),
    .out_addr  (xl_addr),
    .out_hit   (xl_hit)
  );
endmodule

// File: tb/tb_bwx_translator.sv
`timescale 1ns/1ps
module tb_bwx_translator;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_off;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_io;
  logic [31:0] req_addr;
  logic        xl_valid;
  logic [31:0] xl_addr;
  logic        xl_hit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] sh_mem = '0;
  logic [23:0] sh_io  = '0;

  bwx_translator dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_io(req_io),
    .req_addr(req_addr), .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_hit(xl_hit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [32:0] model(input logic io, input logic [31:0] a);
    logic [7:0] b;
    if (io) begin
      if (a[31:8] == 24'hFFFFFC) return {1'b1, sh_io, a[7:0]};
      return 33'd0;
    end
    if (a[31:26] != 6'h12) return 33'd0;
    case (a[25:24])
      2'd0: b = sh_mem[31:24];
      2'd1: b = sh_mem[23:16];
      2'd2: b = sh_mem[15:8];
      default: b = sh_mem[7:0];
    endcase
    return {1'b1, b, a[23:0]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off == 8'h34) sh_mem = d;
    if (off == 8'h30) sh_io = d[23:0];
  endtask

  task automatic do_req(input logic io, input logic [31:0] a, input string rq);
    logic [32:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_addr = a;
    e = model(io, a);
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " valid"}, {31'd0, xl_valid}, 32'd1);
    chk({rq, " hit"}, {31'd0, xl_hit}, {31'd0, e[32]});
    chk({rq, " addr"}, xl_addr, e[31:0]);
  endtask

  function automatic logic [31:0] mem_in(input logic [25:0] lo);
    return {6'h12, lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    logic [31:0] held_a;
    logic        held_h;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cfg_we = 0; cfg_off = 0; cfg_wdata = 0;
    req_valid = 0; req_io = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, xl_valid}, 32'd0);
    chk("R1 reset hit", {31'd0, xl_hit}, 32'd0);
    chk("R1 reset addr", xl_addr, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle valid", {31'd0, xl_valid}, 32'd0);
    do_req(1'b0, mem_in(26'h2ABCDEF), "R1 zero mem base");
    do_req(1'b1, 32'hFFFFFC5A, "R1 zero io base");

    // R2 window byte order
    cfg_write(8'h34, 32'hA1B2C3D4);
    for (int k = 0; k < 4; k++)
      do_req(1'b0, mem_in({k[1:0], 24'h123456}), "R2 window select");
    chk("R2 window3 byte", xl_addr, 32'hD4123456);

    // R3 pass-through of low span
    do_req(1'b0, mem_in({2'd1, 24'hFFFFFF}), "R3 low span");
    chk("R3 explicit", xl_addr, 32'hB2FFFFFF);

    // R4 io base drops upper write byte
    cfg_write(8'h30, 32'hDEADBEEF);
    do_req(1'b1, 32'hFFFFFC00, "R4 io");
    chk("R4 io explicit", xl_addr, 32'hADBEEF00);

    // R5 out-of-range requests
    do_req(1'b0, 32'h4C000000, "R5 mem miss");
    do_req(1'b1, 32'hFFFFFD10, "R5 io miss");
    do_req(1'b0, 32'hFFFFFC10, "R5 io page as mem");

    // R6 hold while idle
    do_req(1'b0, mem_in(26'h0777777), "R6 setup");
    held_a = xl_addr; held_h = xl_hit;
    req_addr = 32'h48000001; req_io = 1'b1;
    @(negedge clk);
    chk("R6 idle valid", {31'd0, xl_valid}, 32'd0);
    chk("R6 hold addr", xl_addr, held_a);
    chk("R6 hold hit", {31'd0, xl_hit}, {31'd0, held_h});

    // R7 other offsets ignored
    cfg_write(8'h38, 32'h11111111);
    cfg_write(8'h00, 32'h22222222);
    cfg_write(8'h31, 32'h33333333);
    do_req(1'b0, mem_in({2'd2, 24'h000001}), "R7 mem unchanged");
    chk("R7 mem explicit", xl_addr, 32'hC3000001);
    do_req(1'b1, 32'hFFFFFC01, "R7 io unchanged");

    // R8 write and request in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = 8'h34; cfg_wdata = 32'h0F1E2D3C;
    req_valid = 1'b1; req_io = 1'b0; req_addr = mem_in(26'h0000042);
    e = model(1'b0, req_addr);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; sh_mem = 32'h0F1E2D3C;
    chk("R8 old value used", xl_addr, e[31:0]);
    chk("R8 old explicit", xl_addr, 32'hA1000042);
    do_req(1'b0, mem_in(26'h0000042), "R8 new value");
    chk("R8 new explicit", xl_addr, 32'h0F000042);

    // R9 contiguous mapping
    cfg_write(8'h34, 32'h40414243);
    for (int k = 0; k < 4; k++) begin
      logic [25:0] lo;
      lo = {k[1:0], 24'(32'h00ABCDEF + k)};
      do_req(1'b0, mem_in(lo), "R9 contiguous");
      chk("R9 linear", xl_addr, 32'h40000000 + {6'd0, lo});
    end

    // Random mix (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      logic [31:0] a;
      r = $urandom % 10;
      if (r < 2) begin
        logic [7:0] o;
        o = ($urandom % 3 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h30 : 8'h34);
        cfg_write(o, $urandom);
      end else begin
        logic io;
        io = ($urandom % 3 == 0);
        a = $urandom;
        if ($urandom % 4 != 0) a = io ? {24'hFFFFFC, a[7:0]} : mem_in(a[25:0]);
        do_req(io, a, "R2-R5 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule